// File: doc/BRIEF.md
# Mirroring Memory Region Decoder

This block turns a 24-bit CPU address into a target choice and a physical offset inside that target. Four targets share the space. A read-only program store sits in the lowest megabyte. External RAM starts at the megabyte boundary and runs up to a configurable end. Two 4 KiB windows sit near the top of the space, one for internal RAM and one for peripheral registers. A target that is physically smaller than its window is folded: the decoder drops the upper offset bits, so the small block shows up again and again across the window. External RAM is never folded.

The selects and the offset are combinational from the address and the valid strobe. A bus master can therefore route the access in the same cycle. The decoder also keeps one registered error flag. On the cycle after a valid access, this flag reports an access that hit no window, or a write aimed at the program store.

Top module: `mirror_region_decoder`

## Requirements
- R1: A valid access to an address below 0x100000 raises select bit 0 (program store). The offset is the address modulo ROM_BYTES, which is a power of two.
- R2: A valid access from 0x100000 up to RAM_END-1 raises select bit 1 (external RAM). The offset is the address minus 0x100000, with no folding.
- R3: A valid access within 0xFFE000 to 0xFFEFFF raises select bit 2 (internal RAM). The offset is the address modulo 1024, so the 1 KiB store repeats four times.
- R4: A valid access within 0xFFF000 to 0xFFFFFF raises select bit 3 (peripheral I/O). The offset is the address modulo 1024.
- R5: A valid access outside all four windows raises no select bit and drives an offset of 0.
- R6: The error output is high in the cycle after a valid access that hit no window. It is low in the cycle after a cycle with valid low.
- R7: A valid write into the program store window sets the error output in the next cycle, while a valid read there leaves it low. In both cases the select and the folded offset are produced as in R1.
- R8: At most one select bit is high at any time. With valid low, all select bits are low and the offset is 0.
- R9: After a synchronous active-low reset the error output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | ADDR_W (24) | CPU byte address |
| valid_i | input | 1 | Access strobe for this cycle |
| write_i | input | 1 | 1 = write, 0 = read |
| sel_o | output | 4 | One-hot target select: bit0 program store, bit1 external RAM, bit2 internal RAM, bit3 peripheral I/O |
| offset_o | output | ADDR_W (24) | Physical offset inside the selected target |
| err_o | output | 1 | Registered access error for the previous cycle |

## Verification
The bench builds the decoder with ROM_BYTES set to 32 KiB and RAM_END set to 0x180000, so the program store folds 32 times across its window. These values also leave a large unmapped gap between the end of external RAM and the internal RAM window. That gap makes the RAM end boundary and the unmapped error path reachable with ordinary addresses. The sweep covers the first and last byte of each window and each 1 KiB and 32 KiB alias seam. Every point is tried as a read, as a write and with valid low.

// File: rtl/mrd_pkg.sv
// Shared constants for the mirroring region decoder.
// Assumes addresses are narrower than 32 bits so that window limits fit a 32-bit value.
package mrd_pkg;
    localparam int NUM_TGT  = 4;
    localparam int TGT_ROM  = 0;
    localparam int TGT_XRAM = 1;
    localparam int TGT_IRAM = 2;
    localparam int TGT_IO   = 3;

    localparam logic [31:0] ROM_WIN_END = 32'h0010_0000;
    localparam logic [31:0] XRAM_BASE   = 32'h0010_0000;
    localparam logic [31:0] IRAM_BASE   = 32'h00FF_E000;
    localparam logic [31:0] IO_BASE     = 32'h00FF_F000;
    localparam logic [31:0] SMALL_WIN   = 32'h0000_1000;

    // True when v is a non-zero power of two.
    function automatic bit is_pow2(input logic [31:0] v);
        return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
    endfunction
endpackage

// File: rtl/mrd_window_match.sv
// Compares an address against one half-open window [LO, HI).
// Assumes ADDR_W < 32 and LO < HI; purely combinational.
module mrd_window_match #(
    parameter int          ADDR_W = 24,
    parameter logic [31:0] LO     = 32'h0,
    parameter logic [31:0] HI     = 32'h1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    logic [31:0] addr_ext;

    // Widen the address and test both window bounds.
    always_comb begin
        addr_ext = 32'(addr_i);
        hit_o    = (addr_ext >= LO) && (addr_ext < HI);
    end
endmodule

// File: rtl/mrd_offset_fold.sv
// Produces the physical offset for the selected target by masking or rebasing.
// Assumes sel_i is one-hot or zero and that both fold sizes are powers of two.
module mrd_offset_fold
    import mrd_pkg::*;
#(
    parameter int          ADDR_W     = 24,
    parameter logic [31:0] ROM_BYTES  = 32'h0004_0000,
    parameter logic [31:0] PHYS_BYTES = 32'h0000_0400
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_TGT-1:0] sel_i,
    output logic [ADDR_W-1:0]  offset_o
);
    localparam logic [ADDR_W-1:0] ROM_MASK  = ADDR_W'(ROM_BYTES - 32'd1);
    localparam logic [ADDR_W-1:0] PHYS_MASK = ADDR_W'(PHYS_BYTES - 32'd1);
    localparam logic [ADDR_W-1:0] XRAM_OFS  = ADDR_W'(XRAM_BASE);

    // Pick the fold rule of whichever target is selected.
    always_comb begin
        offset_o = '0;
        if (sel_i[TGT_ROM])
            offset_o = addr_i & ROM_MASK;
        else if (sel_i[TGT_XRAM])
            offset_o = addr_i - XRAM_OFS;
        else if (sel_i[TGT_IRAM] || sel_i[TGT_IO])
            offset_o = addr_i & PHYS_MASK;
    end
endmodule

// File: rtl/mrd_err_reg.sv
// Registers the access-error flag for one cycle after each access.
// Assumes sel_i is already gated by valid; synchronous active-low reset.
module mrd_err_reg
    import mrd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic               write_i,
    input  logic [NUM_TGT-1:0] sel_i,
    output logic               err_o
);
    logic err_d;

    // An error is either a miss on every window or a store into the program area.
    always_comb begin
        err_d = valid_i && ((sel_i == '0) || (write_i && sel_i[TGT_ROM]));
    end

    // Hold the flag for the cycle following the access.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= err_d;
    end

    AST_MISS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (valid_i && sel_i == '0) |=> err_o); // R6
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !valid_i |=> !err_o); // R6
    AST_ROM_STORE:  assert property (@(posedge clk) disable iff (!rst_n) (valid_i && write_i && sel_i[TGT_ROM]) |=> err_o); // R7
    AST_ROM_LOAD:   assert property (@(posedge clk) disable iff (!rst_n) (valid_i && !write_i && sel_i[TGT_ROM]) |=> !err_o); // R7
endmodule

// File: rtl/mirror_region_decoder.sv
// Top of the mirroring region decoder: matches four windows, folds the offset,
// and registers an access-error flag.
// Assumes ROM_BYTES is a power of two no larger than 1 MiB, PHYS_BYTES is a power
// of two no larger than 4 KiB, and RAM_END lies between 0x100000 and 0xFFE000.
module mirror_region_decoder
    import mrd_pkg::*;
#(
    parameter int          ADDR_W     = 24,
    parameter logic [31:0] ROM_BYTES  = 32'h0004_0000,
    parameter logic [31:0] RAM_END    = 32'h0020_0000,
    parameter logic [31:0] PHYS_BYTES = 32'h0000_0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              valid_i,
    input  logic              write_i,
    output logic [3:0]        sel_o,
    output logic [ADDR_W-1:0] offset_o,
    output logic              err_o
);
    localparam logic [31:0] WIN_LO [NUM_TGT] = '{32'h0, XRAM_BASE, IRAM_BASE, IO_BASE};
    localparam logic [31:0] WIN_HI [NUM_TGT] = '{ROM_WIN_END, RAM_END,
                                                 IRAM_BASE + SMALL_WIN, IO_BASE + SMALL_WIN};

    logic [NUM_TGT-1:0] hit_raw;
    logic [NUM_TGT-1:0] sel_int;

    // One comparator pair per window.
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_win
        mrd_window_match #(
            .ADDR_W (ADDR_W),
            .LO     (WIN_LO[t]),
            .HI     (WIN_HI[t])
        ) u_match (
            .addr_i (addr_i),
            .hit_o  (hit_raw[t])
        );
    end

    // Gate the window hits with the access strobe.
    always_comb begin
        sel_int = valid_i ? hit_raw : '0;
    end

    assign sel_o = sel_int;

    mrd_offset_fold #(
        .ADDR_W     (ADDR_W),
        .ROM_BYTES  (ROM_BYTES),
        .PHYS_BYTES (PHYS_BYTES)
    ) u_fold (
        .addr_i   (addr_i),
        .sel_i    (sel_int),
        .offset_o (offset_o)
    );

    mrd_err_reg u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .write_i (write_i),
        .sel_i   (sel_int),
        .err_o   (err_o)
    );

    AST_ONE_SELECT:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel_o)); // R8
    AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) !valid_i |-> (sel_o == '0 && offset_o == '0)); // R8
    AST_MISS_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) (sel_o == '0) |-> offset_o == '0); // R5
    AST_ROM_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) sel_o[TGT_ROM] |-> 32'(offset_o) < ROM_BYTES); // R1
    AST_IRAM_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) sel_o[TGT_IRAM] |-> 32'(offset_o) < PHYS_BYTES); // R3
    AST_IO_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) sel_o[TGT_IO] |-> 32'(offset_o) < PHYS_BYTES); // R4
    AST_XRAM_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) sel_o[TGT_XRAM] |-> 32'(offset_o) < (RAM_END - XRAM_BASE)); // R2
endmodule

// File: tb/mirror_region_decoder_bench.sv
module mirror_region_decoder_bench;
    localparam int          AW    = 24;
    localparam logic [31:0] ROMB  = 32'h0000_8000;
    localparam logic [31:0] RAMND = 32'h0018_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          valid = 1'b0;
    logic          wr = 1'b0;
    logic [3:0]    sel;
    logic [AW-1:0] offset;
    logic          err;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mirror_region_decoder #(
        .ADDR_W    (AW),
        .ROM_BYTES (ROMB),
        .RAM_END   (RAMND)
    ) u_mirror_region_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr),
        .valid_i  (valid),
        .write_i  (wr),
        .sel_o    (sel),
        .offset_o (offset),
        .err_o    (err)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: returns target index (-1 none) and offset.
    task automatic model(input longint a, output int tgt, output longint ofs);
        tgt = -1; ofs = 0;
        if (a < 64'h100000)                         begin tgt = 0; ofs = a % ROMB; end
        else if (a < RAMND)                         begin tgt = 1; ofs = a - 64'h100000; end
        else if (a >= 64'hFFE000 && a < 64'hFFF000) begin tgt = 2; ofs = a % 1024; end
        else if (a >= 64'hFFF000)                   begin tgt = 3; ofs = a % 1024; end
    endtask

    task automatic access(input longint a, input bit v, input bit w);
        int tgt; longint ofs; longint exp_sel; bit exp_err; string req;
        @(negedge clk);
        addr = AW'(a); valid = v; wr = w;
        model(a, tgt, ofs);
        if (!v) begin tgt = -1; ofs = 0; end
        exp_sel = (tgt < 0) ? 0 : (64'd1 << tgt);
        case (tgt)
            0: req = "R1"; 1: req = "R2"; 2: req = "R3"; 3: req = "R4";
            default: req = v ? "R5" : "R8";
        endcase
        exp_err = v && (tgt < 0 || (w && tgt == 0));
        #1;
        check(req, $sformatf("sel @%0h", a), sel, exp_sel);
        check(req, $sformatf("offset @%0h", a), offset, ofs);
        @(posedge clk); #1;
        if (!v)            req = "R6";
        else if (tgt == 0) req = "R7";
        else if (tgt < 0)  req = "R6";
        check(req, $sformatf("err @%0h w=%0d", a, w), err, exp_err);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        longint pts [] = '{0, 1, 64'h7FFF, 64'h8000, 64'h8005, 64'h7FFFF, 64'hFFFFF,
                           64'h100000, 64'h100001, 64'h17FFFF, 64'h180000, 64'h800000,
                           64'hFFDFFF, 64'hFFE000, 64'hFFE3FF, 64'hFFE400, 64'hFFEFFF,
                           64'hFFF000, 64'hFFF3FF, 64'hFFF400, 64'hFFFBFF, 64'hFFFFFF};
        repeat (3) @(posedge clk);
        #1;
        check("R9", "err in reset", err, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R9", "err after reset", err, 0);
        foreach (pts[i]) begin
            access(pts[i], 1'b1, 1'b0);
            access(pts[i], 1'b1, 1'b1);
            access(pts[i], 1'b0, 1'b1);
        end
        for (int k = 0; k < 64; k++) begin
            access(k * 64'h3F3D1 % 64'h1000000, 1'b1, k[0]);
        end
        // Unmapped write followed by idle: flag must drop again.
        access(64'h400000, 1'b1, 1'b1);
        access(64'h400000, 1'b0, 1'b0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule